// File: doc/BRIEF.md
# Heartbeat-Gated Command Enable Supervisor

This block guards the command path of a backplane against runaway host software. Software arms it by writing to a heartbeat (tick) strobe, and must then keep writing that strobe within a fixed window of clock cycles. A missed window makes the block issue a hardware reset request pulse of fixed length. After the pulse it returns to the idle, disarmed state.

A separate strobe loads a command-enable flag from data bit 0. The flag reaches the backplane only while the supervisor is armed. A disarm strobe stops supervision and clears the command-enable, low-power and system-reset flags, so software has to enable commands again after it re-arms. A synchronous global reset strobe forces the same cleared state at any time, including in the middle of a reset pulse. The block takes pre-decoded write strobes from the surrounding I/O decoder. It drives a 16-bit status word for the control-port read path.

Top module: `fsc_supervisor`

## Requirements
- R1: After rst_ni is released, status_o is 0, bp_cmd_en_o is 0 and hw_rst_o is 0.
- R2: A tick_wr_i strobe while disarmed arms the supervisor. Status bit 14 (armed) reads 1 from the cycle after the strobe.
- R3: While armed, every tick_wr_i restarts the heartbeat window of WINDOW_CYC cycles. If no tick arrives, hw_rst_o rises exactly WINDOW_CYC clock edges after the last tick edge. A tick on the last cycle of the window keeps the supervisor armed.
- R4: The reset request stays high for exactly PULSE_CYC cycles, after which the block is disarmed. The timeout clears the command-enable flag and sets the system-reset flag, status bit 13. Bit 13 stays set until a disarm or a global reset.
- R5: A cmd_wr_i strobe loads the command-enable flag from wdata0_i (1 sets it, 0 clears it).
- R6: bp_cmd_en_o, mirrored on status bit 9, equals the command-enable flag ANDed with the armed state. A flag set while disarmed drives nothing until a tick arms the block.
- R7: A disarm_wr_i strobe disarms the supervisor and clears the command-enable, low-power and system-reset flags. It takes priority over a tick or command write in the same cycle.
- R8: A low_power_i pulse sets the low-power flag, status bit 10. The flag stays set until a disarm or a global reset.
- R9: tick_wr_i has no effect while the reset request is active. The block stays unarmed for the rest of the pulse.
- R10: A gsr_i strobe forces the disarmed state, ends any reset pulse and clears all flags, with priority over every other strobe.
- R11: Status bits other than 9, 10, 13 and 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gsr_i | input | 1 | Synchronous global reset strobe |
| tick_wr_i | input | 1 | Heartbeat write strobe |
| cmd_wr_i | input | 1 | Command-enable write strobe |
| disarm_wr_i | input | 1 | Disarm write strobe |
| wdata0_i | input | 1 | Write data bit 0 |
| low_power_i | input | 1 | Low-power event, sets the low-power flag |
| bp_cmd_en_o | output | 1 | Gated backplane command enable |
| hw_rst_o | output | 1 | Hardware reset request pulse |
| status_o | output | 16 | Control-port status word |

## Verification
Every flag and state change is registered once. Status bits and bp_cmd_en_o therefore settle one clock edge after the strobe that causes them. The bench drives each strobe at a falling edge and files the expected status word and reset level only after the next rising edge. The monitor compares them at the falling edge that follows. The reset request rises exactly WINDOW_CYC edges after the last tick and falls PULSE_CYC edges later. The bench counts idle edges to land its checks on the last quiet cycle, the first reset cycle, and the first cycle after the pulse.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned BIT_BPEN = 9;
  localparam int unsigned BIT_LOWP = 10;
  localparam int unsigned BIT_SRST = 13;
  localparam int unsigned BIT_ARM  = 14;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RESET = 2'd2
  } sup_state_e;

  typedef struct packed {
    logic cmd_en;
    logic low_pwr;
    logic sys_rst;
  } sup_flags_t;
endpackage

// File: rtl/fsc_beat_timer.sv
module fsc_beat_timer #(
  parameter int unsigned WINDOW_CYC = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || restart_i || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a tick on the last cycle of the window wins over expiry
  assign expire_o = run_i && !restart_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/fsc_pulse_gen.sv
module fsc_pulse_gen #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!active_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = active_i && (cnt_q == LAST);
endmodule

// File: rtl/fsc_flags.sv
module fsc_flags
  import fsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kill_i,
  input  logic       timeout_i,
  input  logic       cmd_wr_i,
  input  logic       wdata0_i,
  input  logic       low_power_i,
  output sup_flags_t flags_o
);
  sup_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (kill_i) begin
      flags_d = '0;
    end else begin
      if (timeout_i) begin
        flags_d.cmd_en  = 1'b0;
        flags_d.sys_rst = 1'b1;
      end else if (cmd_wr_i) begin
        flags_d.cmd_en = wdata0_i;
      end
      if (low_power_i) flags_d.low_pwr = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fsc_supervisor.sv
module fsc_supervisor
  import fsc_pkg::*;
#(
  parameter int unsigned WINDOW_CYC = 125_000_000,
  parameter int unsigned PULSE_CYC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gsr_i,
  input  logic              tick_wr_i,
  input  logic              cmd_wr_i,
  input  logic              disarm_wr_i,
  input  logic              wdata0_i,
  input  logic              low_power_i,
  output logic              bp_cmd_en_o,
  output logic              hw_rst_o,
  output logic [STAT_W-1:0] status_o
);
  sup_state_e state_q, state_d;
  sup_flags_t flags;
  logic       kill, expire, pulse_done, timeout, armed;

  assign kill    = gsr_i || disarm_wr_i;
  assign armed   = (state_q == ST_ARMED);
  assign timeout = armed && expire && !kill;

  fsc_beat_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (kill),
    .run_i     (armed),
    .restart_i (tick_wr_i),
    .expire_o  (expire)
  );

  fsc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == ST_RESET),
    .done_o   (pulse_done)
  );

  fsc_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kill_i      (kill),
    .timeout_i   (timeout),
    .cmd_wr_i    (cmd_wr_i),
    .wdata0_i    (wdata0_i),
    .low_power_i (low_power_i),
    .flags_o     (flags)
  );

  always_comb begin
    state_d = state_q;
    if (kill) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (tick_wr_i)  state_d = ST_ARMED;
        ST_ARMED: if (expire)     state_d = ST_RESET;
        ST_RESET: if (pulse_done) state_d = ST_IDLE;
        default:                  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign bp_cmd_en_o = flags.cmd_en && armed;
  assign hw_rst_o    = (state_q == ST_RESET);

  always_comb begin
    status_o           = '0;
    status_o[BIT_BPEN] = bp_cmd_en_o;
    status_o[BIT_LOWP] = flags.low_pwr;
    status_o[BIT_SRST] = flags.sys_rst;
    status_o[BIT_ARM]  = armed;
  end
endmodule

// File: rtl/fsc_supervisor_chk.sv
module fsc_supervisor_chk #(
  parameter int unsigned WINDOW_CYC = 125_000_000,
  parameter int unsigned PULSE_CYC  = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        gsr_i,
  input logic        tick_wr_i,
  input logic        cmd_wr_i,
  input logic        disarm_wr_i,
  input logic        wdata0_i,
  input logic        bp_cmd_en_o,
  input logic        hw_rst_o,
  input logic [15:0] status_o
);
  logic [31:0] gap_q, hi_q;
  logic        quiet;
  assign quiet = !gsr_i && !disarm_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= 32'd0;
      hi_q  <= 32'd0;
    end else begin
      if (tick_wr_i) gap_q <= 32'd0;
      else if (gap_q <= WINDOW_CYC) gap_q <= gap_q + 32'd1;
      hi_q <= hw_rst_o ? hi_q + 32'd1 : 32'd0;
    end
  end

  a_r2_tick_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_wr_i && quiet && !hw_rst_o) |=> status_o[14]);

  a_r3_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hw_rst_o) |-> (gap_q == WINDOW_CYC));

  a_r4_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hw_rst_o) && !$past(gsr_i || disarm_wr_i)) |-> (hi_q == PULSE_CYC && !status_o[14]));

  a_r5_cmd_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[14] && tick_wr_i && cmd_wr_i && quiet) |=> (bp_cmd_en_o == $past(wdata0_i)));

  a_r6_bp_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_cmd_en_o |-> (status_o[14] && !hw_rst_o));

  a_r7_disarm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_wr_i |=> (status_o == 16'h0 && !hw_rst_o && !bp_cmd_en_o));

  a_r9_tick_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_rst_o && tick_wr_i) |=> !status_o[14]);

  a_r10_gsr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsr_i |=> (status_o == 16'h0 && !hw_rst_o));

  a_r11_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 16'h99FF) == 16'h0);
endmodule

bind fsc_supervisor fsc_supervisor_chk #(
  .WINDOW_CYC(WINDOW_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gsr_i       (gsr_i),
  .tick_wr_i   (tick_wr_i),
  .cmd_wr_i    (cmd_wr_i),
  .disarm_wr_i (disarm_wr_i),
  .wdata0_i    (wdata0_i),
  .bp_cmd_en_o (bp_cmd_en_o),
  .hw_rst_o    (hw_rst_o),
  .status_o    (status_o)
);

// File: tb/test_fsc_supervisor.sv
`timescale 1ns/1ps
module test_fsc_supervisor;
  localparam int W = 20;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gsr = 0, tick = 0, cmd = 0, dis = 0, d0 = 0, lp = 0;
  logic bp_en, hw_rst;
  logic [15:0] status;

  typedef struct {
    logic [15:0] st;
    logic        rst;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsc_supervisor #(.WINDOW_CYC(W), .PULSE_CYC(P)) i_fsc_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .gsr_i(gsr), .tick_wr_i(tick),
    .cmd_wr_i(cmd), .disarm_wr_i(dis), .wdata0_i(d0), .low_power_i(lp),
    .bp_cmd_en_o(bp_en), .hw_rst_o(hw_rst), .status_o(status)
  );

  // status bits: 9 bp enable, 10 low power, 13 system reset, 14 armed
  function automatic logic [15:0] mk(input logic b, input logic l, input logic s, input logic a);
    mk = 16'h0;
    mk[9] = b; mk[10] = l; mk[13] = s; mk[14] = a;
  endfunction

  task automatic step(input logic tk, input logic cm, input logic dv, input logic ds,
                      input logic lw, input logic gs, input logic chk,
                      input logic [15:0] es, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    tick = tk; cmd = cm; d0 = dv; dis = ds; lp = lw; gsr = gs;
    @(posedge clk);
    #1;
    if (chk) begin
      e.st = es; e.rst = er; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 16'h0, 0, "");
  endtask

  // monitor: compare at the falling edge after each registered update
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (status !== e.st || hw_rst !== e.rst || bp_en !== e.st[9]) begin
        bad++;
        $display("FAIL %s: status=%h rst=%b bp=%b expected status=%h rst=%b bp=%b",
                 e.tag, status, hw_rst, bp_en, e.st, e.rst, e.st[9]);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(0,0,0,0,0,0, 1, mk(0,0,0,0), 0, "R1 reset state");
    // R6 flag set while disarmed stays off the backplane
    step(0,1,1,0,0,0, 1, mk(0,0,0,0), 0, "R6 flag while disarmed");
    step(1,0,0,0,0,0, 1, mk(1,0,0,1), 0, "R2 R6 tick arms, flag appears");
    step(1,0,0,0,1,0, 1, mk(1,1,0,1), 0, "R8 low power set");
    step(1,1,0,0,0,0, 1, mk(0,1,0,1), 0, "R5 load D0=0");
    step(1,1,1,0,0,0, 1, mk(1,1,0,1), 0, "R5 load D0=1");
    // R3 tick on last window cycle keeps armed
    idle(W-1);
    step(1,0,0,0,0,0, 1, mk(1,1,0,1), 0, "R3 tick at window end");
    idle(W-2);
    step(0,0,0,0,0,0, 1, mk(1,1,0,1), 0, "R3 last quiet cycle");
    step(1,0,0,0,0,0, 1, mk(1,1,0,1), 0, "R3 rescued by late tick");
    // R7 disarm
    step(0,0,0,1,0,0, 1, mk(0,0,0,0), 0, "R7 disarm clears");
    step(1,0,0,0,0,0, 1, mk(0,0,0,1), 0, "R7 re-armed without flag");
    step(1,1,1,0,0,0, 1, mk(1,0,0,1), 0, "R5 re-enable");
    step(1,0,0,0,1,0, 1, mk(1,1,0,1), 0, "R8 low power again");
    step(1,1,1,1,0,0, 1, mk(0,0,0,0), 0, "R7 disarm wins same cycle");
    // timeout path
    step(1,1,1,0,0,0, 1, mk(1,0,0,1), 0, "R2 arm for timeout");
    idle(W-2);
    step(0,0,0,0,0,0, 1, mk(1,0,0,1), 0, "R3 no reset before window");
    step(0,0,0,0,0,0, 1, mk(0,0,1,0), 1, "R3 R4 reset request rises");
    step(1,0,0,0,0,0, 1, mk(0,0,1,0), 1, "R9 tick during pulse ignored");
    step(0,0,0,0,0,0, 1, mk(0,0,1,0), 1, "R4 pulse held");
    step(0,0,0,0,0,0, 1, mk(0,0,1,0), 1, "R4 pulse last cycle");
    step(0,0,0,0,0,0, 1, mk(0,0,1,0), 0, "R4 pulse ended, disarmed");
    step(1,0,0,0,0,0, 1, mk(0,0,1,1), 0, "R4 flag cleared by timeout");
    step(1,0,0,0,1,0, 1, mk(0,1,1,1), 0, "R8 low power sticky");
    step(1,1,1,0,0,0, 1, mk(1,1,1,1), 0, "R11 all status bits set");
    step(1,1,1,0,1,1, 1, mk(0,0,0,0), 0, "R10 gsr priority");
    // R10 gsr ends a pulse
    step(1,0,0,0,0,0, 1, mk(0,0,0,1), 0, "R2 arm again");
    idle(W-1);
    step(0,0,0,0,0,0, 1, mk(0,0,1,0), 1, "R3 second timeout");
    step(0,0,0,0,0,0, 1, mk(0,0,1,0), 1, "R4 pulse running");
    step(0,0,0,0,0,1, 1, mk(0,0,0,0), 0, "R10 gsr ends pulse");
    idle(2);
    @(negedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule